// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of general-purpose pins, up to 32 wide, controlled through a plain 32-bit register port. Each pin is either a plain I/O or an interrupt source, set by a per-pin function bit. In plain I/O mode a direction bit decides whether the bank drives the pin. An output-data register supplies the drive value. Pin levels pass through a two-flop synchronizer before software or the detection logic sees them.

An interrupt-mode pin can watch for a high level, a low level, a rising edge, a falling edge or either edge. Three per-pin bitmaps choose the mode: polarity, edge-versus-level and dual-edge. Detected events land in a status bitmap. Status is cleared through a write-one-to-clear register. Enables are managed through two registers. One sets enable bits where a one is written. The other keeps enable bits only where a one is written. A single level-sensitive interrupt line is raised while any enabled status bit is set.

Software reads a register combinationally: it presents `bus_addr` and reads `bus_rdata`. A write takes effect at the clock edge where `bus_we` is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` is 0 and `irq` is 0.
- R2: The byte addresses are: function 0x00, direction 0x04, output data 0x08, polarity 0x20, edge select 0x24 and dual-edge 0x4C. Each of these reads back the last value written. The clear register 0x14 and the enable-set register 0x1C read as 0.
- R3: A `pin_oe` bit is 1 only when that pin's function bit is 0 (plain I/O) and its direction bit is 1 (output).
- R4: `pin_out` always equals the output-data register, even while the pin is an input, so a value can be loaded before the pin is switched to output.
- R5: The input register (0x0C) returns each pin's level as seen after the two-flop synchronizer.
- R6: For a pin with function 1 and edge-select 0 (level mode), the status bit at 0x10 follows the synchronized level XOR the polarity bit on every cycle. Polarity 1 means active low.
- R7: For a pin with function 1, edge-select 1 and dual-edge 0, polarity 0 sets status on a rising edge and polarity 1 sets it on a falling edge. The status bit stays set after the pin returns to its idle level.
- R8: With edge-select 1 and dual-edge 1, either edge sets status and the polarity bit has no effect.
- R9: Writing 0x14 clears each edge-mode status bit written as 1 and leaves bits written as 0 unchanged. If an edge arrives in the same cycle as its clear, the bit stays set.
- R10: Writing 0x1C sets the enable bit of each pin written as 1. Writing 0x18 clears the enable bit of each pin written as 0 and leaves pins written as 1 unchanged. The enable bits read at 0x18.
- R11: `irq` is 1 exactly when some pin has both its status bit and its enable bit set.
- R12: A pin whose function bit is 0 never sets its status bit, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Pin drive values |
| pin_oe | output | NPINS | Pin output enables |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
The assertions assume that a write strobe lasts one clock with a stable address, and that the upper data bits beyond the pin count are ignored. The bench holds `bus_we` for a single cycle per write, moving all bus and pin inputs on the falling edge. The dual-edge and clear checks assume the configuration is not rewritten during the cycles when an edge is being registered. The stimulus sets the mode bits first and only then moves the pin inputs. The one test that makes a clear and a set meet in the same cycle times the write to the exact edge at which the synchronized sample changes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int MAX_PINS = 32;
    localparam int AW       = 7;

    localparam logic [AW-1:0] OFS_FUNC  = 7'h00;
    localparam logic [AW-1:0] OFS_DIR   = 7'h04;
    localparam logic [AW-1:0] OFS_OUT   = 7'h08;
    localparam logic [AW-1:0] OFS_IN    = 7'h0C;
    localparam logic [AW-1:0] OFS_STAT  = 7'h10;
    localparam logic [AW-1:0] OFS_CLR   = 7'h14;
    localparam logic [AW-1:0] OFS_EN    = 7'h18;
    localparam logic [AW-1:0] OFS_ENSET = 7'h1C;
    localparam logic [AW-1:0] OFS_POL   = 7'h20;
    localparam logic [AW-1:0] OFS_EDGE  = 7'h24;
    localparam logic [AW-1:0] OFS_BOTH  = 7'h4C;

    // Per-pin detection configuration
    typedef struct packed {
        logic irq_mode;   // 1: interrupt source
        logic neg;        // 1: active low / falling edge
        logic edge_mode;  // 1: edge, 0: level
        logic dual;       // 1: both edges
    } pin_cfg_t;

    // Detection result for one pin: level-mode value or edge event
    function automatic logic pin_hit(pin_cfg_t c, logic cur, logic prev);
        logic h;
        if (!c.irq_mode)
            h = 1'b0;
        else if (!c.edge_mode)
            h = cur ^ c.neg;
        else if (c.dual)
            h = cur ^ prev;
        else if (c.neg)
            h = ~cur & prev;
        else
            h = cur & ~prev;
        return h;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] cur,
    output logic [N-1:0] prev
);
    logic [N-1:0] meta_q;
    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/gpio_event.sv
module gpio_event
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] func,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] edg,
    input  logic [N-1:0] both,
    input  logic [N-1:0] cur,
    input  logic [N-1:0] prev,
    output logic [N-1:0] hit
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        pin_cfg_t cfg;
        always_comb begin
            cfg.irq_mode  = func[i];
            cfg.neg       = pol[i];
            cfg.edge_mode = edg[i];
            cfg.dual      = both[i];
        end
        assign hit[i] = pin_hit(cfg, cur[i], prev[i]);
    end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata,
    input  logic [N-1:0]  level,
    input  logic [N-1:0]  hit,
    output logic [N-1:0]  func_q,
    output logic [N-1:0]  dir_q,
    output logic [N-1:0]  out_q,
    output logic [N-1:0]  pol_q,
    output logic [N-1:0]  edg_q,
    output logic [N-1:0]  both_q,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  st_q
);
    logic [N-1:0] wd;
    logic         clr_wr;

    assign wd     = wdata[N-1:0];
    assign clr_wr = we && (addr == OFS_CLR);

    function automatic logic [31:0] widen(logic [N-1:0] v);
        logic [31:0] r;
        r        = '0;
        r[N-1:0] = v;
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            pol_q  <= '0;
            edg_q  <= '0;
            both_q <= '0;
            en_q   <= '0;
        end else if (we) begin
            case (addr)
                OFS_FUNC:  func_q <= wd;
                OFS_DIR:   dir_q  <= wd;
                OFS_OUT:   out_q  <= wd;
                OFS_POL:   pol_q  <= wd;
                OFS_EDGE:  edg_q  <= wd;
                OFS_BOTH:  both_q <= wd;
                OFS_EN:    en_q   <= en_q & wd;
                OFS_ENSET: en_q   <= en_q | wd;
                default: ;
            endcase
        end
    end

    // Status: level pins track, edge pins latch until cleared, set wins
    for (genvar i = 0; i < N; i++) begin : g_st
        always_ff @(posedge clk) begin
            if (rst)
                st_q[i] <= 1'b0;
            else if (!edg_q[i])
                st_q[i] <= hit[i];
            else
                st_q[i] <= hit[i] | (st_q[i] & ~(clr_wr & wd[i]));
        end
    end

    always_comb begin
        case (addr)
            OFS_FUNC: rdata = widen(func_q);
            OFS_DIR:  rdata = widen(dir_q);
            OFS_OUT:  rdata = widen(out_q);
            OFS_IN:   rdata = widen(level);
            OFS_STAT: rdata = widen(st_q);
            OFS_EN:   rdata = widen(en_q);
            OFS_POL:  rdata = widen(pol_q);
            OFS_EDGE: rdata = widen(edg_q);
            OFS_BOTH: rdata = widen(both_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [6:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    logic [NPINS-1:0] cur, prev, hit;
    logic [NPINS-1:0] func_q, dir_q, out_q, pol_q, edg_q, both_q, en_q, st_q;

    gpio_sync #(.N(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .raw (pin_in),
        .cur (cur),
        .prev(prev)
    );

    gpio_event #(.N(NPINS)) u_event (
        .func(func_q),
        .pol (pol_q),
        .edg (edg_q),
        .both(both_q),
        .cur (cur),
        .prev(prev),
        .hit (hit)
    );

    gpio_regs #(.N(NPINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .level (cur),
        .hit   (hit),
        .func_q(func_q),
        .dir_q (dir_q),
        .out_q (out_q),
        .pol_q (pol_q),
        .edg_q (edg_q),
        .both_q(both_q),
        .en_q  (en_q),
        .st_q  (st_q)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q & ~func_q;
    assign irq     = |(st_q & en_q);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_we,
    input logic [6:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] en_q,
    input logic [NPINS-1:0] st_q,
    input logic [NPINS-1:0] edg_q
);
    AST_OE_OFF_IN_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_FUNC) |=> ((pin_oe & $past(bus_wdata[NPINS-1:0])) == '0)); // R3

    AST_ENSET_SETS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_ENSET) |=>
        ((en_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]))); // R10

    AST_EN_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_EN) |=> ((en_q & ~$past(bus_wdata[NPINS-1:0])) == '0)); // R10

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_q != '0)); // R11

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_q != '0)); // R11

    AST_EDGE_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == OFS_CLR) |=>
        (($past(st_q & edg_q) & ~st_q & edg_q) == '0)); // R7
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .en_q     (en_q),
    .st_q     (st_q),
    .edg_q    (edg_q)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_bank #(.NPINS(NP)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; pin_in = '0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic t_reset();
        rd_chk(7'h00, 0, "R1 func"); rd_chk(7'h04, 0, "R1 dir");
        rd_chk(7'h08, 0, "R1 out"); rd_chk(7'h10, 0, "R1 status");
        rd_chk(7'h18, 0, "R1 enable"); rd_chk(7'h4C, 0, "R1 both");
        check(pin_oe == 0 && irq == 0, "R1 oe/irq", {pin_oe[30:0], irq}, 0);
    endtask

    task automatic t_regs();
        wr(7'h04, 32'h0000_F00F); wr(7'h20, 32'h1234_5678);
        wr(7'h24, 32'h8000_0001); wr(7'h4C, 32'h0F0F_0000);
        rd_chk(7'h04, 32'h0000_F00F, "R2 dir");
        rd_chk(7'h20, 32'h1234_5678, "R2 pol");
        rd_chk(7'h24, 32'h8000_0001, "R2 edge");
        rd_chk(7'h4C, 32'h0F0F_0000, "R2 both");
        rd_chk(7'h14, 0, "R2 clr reads 0");
        rd_chk(7'h1C, 0, "R2 enset reads 0");
        wr(7'h04, 0); wr(7'h20, 0); wr(7'h24, 0); wr(7'h4C, 0);
    endtask

    task automatic t_output();
        wr(7'h08, 32'hA5A5_0003);
        check(pin_out == 32'hA5A5_0003 && pin_oe == 0, "R4 preload", pin_out, 32'hA5A5_0003);
        wr(7'h04, 32'h0000_0003);
        check(pin_oe == 32'h3, "R3 oe on", pin_oe, 32'h3);
        wr(7'h00, 32'h0000_0001);
        check(pin_oe == 32'h2, "R3 oe off in irq mode", pin_oe, 32'h2);
        rd_chk(7'h08, 32'hA5A5_0003, "R2 out readback");
        wr(7'h00, 0); wr(7'h04, 0); wr(7'h08, 0);
    endtask

    task automatic t_input();
        pin_in = 32'hC0DE_0042;
        step(3);
        rd_chk(7'h0C, 32'hC0DE_0042, "R5 input");
        pin_in = 0;
        step(3);
        rd_chk(7'h0C, 0, "R5 input low");
    endtask

    task automatic t_level();
        // pin0 high level, pin1 low level
        wr(7'h20, 32'h2); wr(7'h00, 32'h3); wr(7'h1C, 32'h3);
        step(3);
        rd_chk(7'h10, 32'h2, "R6 low-level active while 0");
        check(irq == 1, "R11 irq level", irq, 1);
        pin_in = 32'h3;
        step(3);
        rd_chk(7'h10, 32'h1, "R6 follows level");
        pin_in = 32'h2;
        step(3);
        rd_chk(7'h10, 32'h0, "R6 both idle");
        check(irq == 0, "R11 irq off", irq, 0);
        wr(7'h18, 0); wr(7'h00, 0); wr(7'h20, 0); pin_in = 0; step(3);
    endtask

    task automatic t_edge();
        // pin2 rising, pin3 falling
        wr(7'h20, 32'h8); wr(7'h24, 32'hC); wr(7'h00, 32'hC);
        pin_in = 32'hC;
        step(4);
        rd_chk(7'h10, 32'h4, "R7 rising set");
        pin_in = 0;
        step(4);
        rd_chk(7'h10, 32'hC, "R7 falling set, rising held");
        wr(7'h14, 32'h4);
        rd_chk(7'h10, 32'h8, "R9 clear selected bit only");
        wr(7'h14, 32'h8);
        rd_chk(7'h10, 32'h0, "R9 clear second");
        wr(7'h00, 0); wr(7'h20, 0); wr(7'h24, 0);
    endtask

    task automatic t_both();
        // pin4 dual edge with polarity set (ignored)
        wr(7'h20, 32'h10); wr(7'h24, 32'h10); wr(7'h4C, 32'h10); wr(7'h00, 32'h10);
        pin_in = 32'h10;
        step(4);
        rd_chk(7'h10, 32'h10, "R8 rise detected");
        wr(7'h14, 32'h10);
        rd_chk(7'h10, 0, "R9 cleared");
        pin_in = 0;
        step(4);
        rd_chk(7'h10, 32'h10, "R8 fall detected");
        wr(7'h14, 32'h10);
        // set wins over clear in same cycle
        pin_in = 32'h10;
        step(2);
        wr(7'h14, 32'h10);
        rd_chk(7'h10, 32'h10, "R9 set wins");
        wr(7'h14, 32'h10);
        wr(7'h00, 0); wr(7'h20, 0); wr(7'h24, 0); wr(7'h4C, 0); pin_in = 0; step(3);
    endtask

    task automatic t_enable();
        wr(7'h1C, 32'h0000_00F0);
        wr(7'h1C, 32'h0000_0003);
        rd_chk(7'h18, 32'hF3, "R10 enable set ors");
        wr(7'h18, 32'hFFFF_FF7F);
        rd_chk(7'h18, 32'h73, "R10 write 0 clears one");
        // pin5 rising edge, enabled -> irq; disable -> irq drops, status kept
        wr(7'h24, 32'h20); wr(7'h00, 32'h20);
        pin_in = 32'h20;
        step(4);
        check(irq == 1, "R11 irq on enabled edge", irq, 1);
        wr(7'h18, 32'hFFFF_FFDF);
        check(irq == 0, "R11 irq masked", irq, 0);
        rd_chk(7'h10, 32'h20, "R10 status kept when masked");
        wr(7'h14, 32'h20); wr(7'h18, 0); wr(7'h00, 0); wr(7'h24, 0); pin_in = 0; step(3);
    endtask

    task automatic t_gpio_mode();
        wr(7'h24, 32'hFF); wr(7'h4C, 32'hFF); wr(7'h1C, 32'hFF);
        pin_in = 32'hFF; step(4); pin_in = 0; step(4);
        rd_chk(7'h10, 0, "R12 no status in gpio mode");
        check(irq == 0, "R12 no irq", irq, 0);
        wr(7'h18, 0); wr(7'h24, 0); wr(7'h4C, 0);
    endtask

    initial begin
        step(1);
        fork
            begin
                do_reset();
                t_reset();
                t_regs();
                t_output();
                t_input();
                t_level();
                t_edge();
                t_both();
                t_enable();
                t_gpio_mode();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule